// File: doc/BRIEF.md
# Prescaled Periodic Interval Timer

This block is a programmable interval timer that raises a periodic interrupt for a processor core. An 8-bit scale register sets the prescale ratio: the value held there is one less than the number of core clock cycles between timer ticks, so a stored 0 gives one tick on every cycle. On each tick a 16-bit down-counter steps toward zero. When it gets there, the block raises its interrupt and loads the counter again from a 16-bit period register, so the interrupt repeats without software help.

Software writes the count, period and scale registers through three write strobes that share one data bus. It starts and stops the timer with a level enable. The current count is always visible on `count_q`. A small controller with three states drives the interrupt pulse. `ST_HALTED` means the enable is low. `ST_RUNNING` means the timer is enabled and no expiry happened on the last edge. `ST_EXPIRED` is the one cycle after an expiry, and `irq` is high only in this state. The controller decides its next state at every edge, in this order: an expiry goes to `ST_EXPIRED` from any state; otherwise a high enable goes to `ST_RUNNING`; otherwise the controller goes to `ST_HALTED`. If expiries happen on consecutive edges, the controller stays in `ST_EXPIRED` and `irq` stays high.

An expiry is a tick in which the counter holds 1 or 0 and no count write takes place. Because of this rule, a period of P ≥ 1 gives exactly one interrupt every P ticks.

Top module: `prescaled_interval_timer`

## Requirements
- R1: When reset is released, `count_q` is 0 and `irq` is low. The period and scale registers also hold 0, so the prescaler's first reload gives a ratio of one.
- R2: On a tick where the counter is above 1 and `wr_count` is low, `count_q` drops by exactly one after that clock edge.
- R3: Ticks come every S+1 enabled cycles, where S is the scale value that the prescaler loaded at its last reload. With S = 0 there is a tick on every enabled cycle. Once reset is released, the first enabled cycle is a tick.
- R4: On a tick where the counter holds 1 or 0 and `wr_count` is low, the counter loads the period value. In the cycle after that edge, `irq` is high. At all other times `irq` is low.
- R5: With a period of 0, every tick is an expiry, so `irq` follows each tick.
- R6: While `enable` is low, the counter and the prescaler hold their values, and `irq` goes low from the next cycle.
- R7: A `wr_count` strobe loads `wr_data` into the counter at the next edge. It overrides any tick in that cycle, so that cycle gives no interrupt.
- R8: A `wr_scale` strobe (which writes `wr_data[7:0]`) does not change the interval already in progress. The new scale first applies at the prescaler's next reload after the write cycle.
- R9: A `wr_period` strobe does not change the counter. The new period is used at the next expiry after the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the prescaler and the counter while high |
| wr_count | input | 1 | Writes `wr_data` into the down-counter |
| wr_period | input | 1 | Writes `wr_data` into the period register |
| wr_scale | input | 1 | Writes `wr_data[7:0]` into the scale register |
| wr_data | input | 16 | Shared write data |
| count_q | output | 16 | Current counter value |
| irq | output | 1 | High for one cycle after each expiry |

## Verification
A stuck or wrongly reloaded prescaler changes when the ticks fall. The first sign is `count_q` stepping one cycle early or late, seen at the very next tick. A wrong reload value or a wrong expiry decision shows as a wrong `count_q` in the cycle after the expiry edge, together with a missing or extra `irq`. A wrong state in the controller shows in `irq` one cycle after the edge that caused it. The scoreboard compares both outputs on every cycle against a model built from the requirements, so any fault appears within one tick interval of its cause.

// File: rtl/pit_pkg.sv
package pit_pkg;
    typedef enum logic [1:0] {
        ST_HALTED  = 2'd0,
        ST_RUNNING = 2'd1,
        ST_EXPIRED = 2'd2
    } pit_state_e;
endpackage

// File: rtl/pit_cfg_regs.sv
module pit_cfg_regs #(
    parameter int CNT_W = 16,
    parameter int SCL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_period,
    input  logic             wr_scale,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] period_o,
    output logic [SCL_W-1:0] scale_o
);
    logic [CNT_W-1:0] period_r;
    logic [SCL_W-1:0] scale_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_r <= '0;
        end else if (wr_period) begin
            period_r <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scale_r <= '0;
        end else if (wr_scale) begin
            scale_r <= wr_data[SCL_W-1:0];
        end
    end

    assign period_o = period_r;
    assign scale_o  = scale_r;

    AST_PERIOD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_period |=> $stable(period_o)); // R9
    AST_SCALE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_scale |=> $stable(scale_o)); // R8
endmodule

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
    parameter int SCL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [SCL_W-1:0] scale_i,
    output logic             tick_o
);
    logic [SCL_W-1:0] div_q;
    logic             div_zero;

    assign div_zero = (div_q == '0);
    assign tick_o   = enable && div_zero;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (enable) begin
            if (div_zero) begin
                div_q <= scale_i;
            end else begin
                div_q <= div_q - 1'b1;
            end
        end
    end

    AST_PRESC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(div_q)); // R6
    AST_PRESC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> div_q == $past(scale_i)); // R8
    AST_PRESC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !tick_o) |=> div_q == $past(div_q) - 1'b1); // R3
endmodule

// File: rtl/pit_down_counter.sv
module pit_down_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             wr_count,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             at_end;

    assign at_end   = (cnt_q <= ONE);
    assign expire_o = tick_i && !wr_count && at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_count) begin
            cnt_q <= wr_data;
        end else if (tick_i) begin
            if (at_end) begin
                cnt_q <= period_i;
            end else begin
                cnt_q <= cnt_q - ONE;
            end
        end
    end

    assign count_o = cnt_q;

    AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !wr_count && cnt_q > ONE) |=> count_o == $past(cnt_q) - ONE); // R2
    AST_RELOAD_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> count_o == $past(period_i)); // R4
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !wr_count) |=> $stable(count_o)); // R6
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_count |=> count_o == $past(wr_data)); // R7
endmodule

// File: rtl/pit_ctrl_fsm.sv
module pit_ctrl_fsm
    import pit_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic expire_i,
    output logic irq_o
);
    pit_state_e state_q;
    pit_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALTED: begin
                if (expire_i)    state_d = ST_EXPIRED;
                else if (enable) state_d = ST_RUNNING;
                else             state_d = ST_HALTED;
            end
            ST_RUNNING: begin
                if (expire_i)    state_d = ST_EXPIRED;
                else if (enable) state_d = ST_RUNNING;
                else             state_d = ST_HALTED;
            end
            ST_EXPIRED: begin
                if (expire_i)    state_d = ST_EXPIRED;
                else if (enable) state_d = ST_RUNNING;
                else             state_d = ST_HALTED;
            end
            default: state_d = ST_HALTED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALTED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        irq_o = (state_q == ST_EXPIRED);
    end

    AST_IRQ_AFTER_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> irq_o); // R4
    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(expire_i)); // R4
    AST_HALT_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !expire_i) |=> state_q == ST_HALTED); // R6
endmodule

// File: rtl/prescaled_interval_timer.sv
module prescaled_interval_timer #(
    parameter int CNT_W = 16,
    parameter int SCL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             wr_count,
    input  logic             wr_period,
    input  logic             wr_scale,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count_q,
    output logic             irq
);
    logic [CNT_W-1:0] period_w;
    logic [SCL_W-1:0] scale_w;
    logic             tick_w;
    logic             expire_w;

    pit_cfg_regs #(.CNT_W(CNT_W), .SCL_W(SCL_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_period (wr_period),
        .wr_scale  (wr_scale),
        .wr_data   (wr_data),
        .period_o  (period_w),
        .scale_o   (scale_w)
    );

    pit_prescaler #(.SCL_W(SCL_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .scale_i (scale_w),
        .tick_o  (tick_w)
    );

    pit_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_w),
        .wr_count (wr_count),
        .wr_data  (wr_data),
        .period_i (period_w),
        .count_o  (count_q),
        .expire_o (expire_w)
    );

    pit_ctrl_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .expire_i (expire_w),
        .irq_o    (irq)
    );

    AST_NO_TICK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !tick_w); // R6
    AST_WRITE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        wr_count |=> !irq); // R7
endmodule

// File: tb/sim_prescaled_interval_timer.sv
module sim_prescaled_interval_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        wr_count = 1'b0;
    logic        wr_period = 1'b0;
    logic        wr_scale = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] count_q;
    logic        irq;

    int total = 0;
    int fails = 0;

    logic [15:0] exp_cnt[$];
    logic        exp_irq[$];
    string       exp_tag[$];

    int m_count = 0;
    int m_period = 0;
    int m_scale = 0;
    int m_presc = 0;

    always #5 clk = ~clk;

    prescaled_interval_timer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .wr_count  (wr_count),
        .wr_period (wr_period),
        .wr_scale  (wr_scale),
        .wr_data   (wr_data),
        .count_q   (count_q),
        .irq       (irq)
    );

    task automatic check(input string tag, input logic [15:0] c_act, input logic [15:0] c_exp,
                         input logic i_act, input logic i_exp);
        total++;
        if (c_act !== c_exp || i_act !== i_exp) begin
            fails++;
            $display("FAIL %s: count=%0d irq=%0b expected count=%0d irq=%0b at %0t",
                     tag, c_act, i_act, c_exp, i_exp, $time);
        end
    endtask

    // Monitor: compare each cycle's outputs against the scoreboard queue.
    always @(negedge clk) begin
        if (exp_cnt.size() > 0) begin
            check(exp_tag.pop_front(), count_q, exp_cnt.pop_front(), irq, exp_irq.pop_front());
        end
    end

    // Driver: apply one cycle of stimulus, advance the model, push the expectation.
    task automatic step(input bit en, input bit wc, input bit wp, input bit ws,
                        input int d, input string tag);
        bit tick;
        bit fire;
        enable    = en;
        wr_count  = wc;
        wr_period = wp;
        wr_scale  = ws;
        wr_data   = d[15:0];
        tick = en && (m_presc == 0);
        fire = tick && !wc && (m_count <= 1);
        @(posedge clk);
        if (wc)        m_count = d & 16'hFFFF;
        else if (tick) m_count = (m_count <= 1) ? m_period : m_count - 1;
        if (en)        m_presc = (m_presc == 0) ? m_scale : m_presc - 1;
        if (wp)        m_period = d & 16'hFFFF;
        if (ws)        m_scale = d & 8'hFF;
        exp_cnt.push_back(m_count[15:0]);
        exp_irq.push_back(fire);
        exp_tag.push_back(tag);
        #1;
        wr_count  = 1'b0;
        wr_period = 1'b0;
        wr_scale  = 1'b0;
    endtask

    task automatic run(input int n, input bit en, input string tag);
        for (int i = 0; i < n; i++) step(en, 1'b0, 1'b0, 1'b0, 0, tag);
    endtask

    initial begin
        #2_000_000;
        fails++;
        total++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1", count_q, 16'd0, irq, 1'b0);
        @(posedge clk);
        #1;

        // R1: reset period/scale are zero: enabled with count 0 fires each cycle
        run(3, 1'b1, "R1");
        run(2, 1'b0, "R6");

        // R2/R4: scale 0, period 5, count 3
        step(1'b0, 1'b0, 1'b1, 1'b0, 5, "R9");
        step(1'b0, 1'b1, 1'b0, 1'b0, 3, "R7");
        run(16, 1'b1, "R2");
        run(6, 1'b1, "R4");

        // R3: scale 3 gives a tick every 4 enabled cycles
        step(1'b1, 1'b0, 1'b0, 1'b1, 3, "R8");
        run(40, 1'b1, "R3");

        // R6: pause mid-interval, counter and prescaler hold
        run(10, 1'b0, "R6");
        run(12, 1'b1, "R6");

        // R5: period 0 with scale 2 fires on every tick
        step(1'b1, 1'b0, 1'b0, 1'b1, 2, "R5");
        step(1'b1, 1'b0, 1'b1, 1'b0, 0, "R5");
        run(24, 1'b1, "R5");

        // R7: count write at a tick where expiry would happen
        step(1'b1, 1'b0, 1'b0, 1'b1, 0, "R7");
        step(1'b1, 1'b0, 1'b1, 1'b0, 4, "R7");
        run(4, 1'b1, "R7");
        step(1'b1, 1'b1, 1'b0, 1'b0, 1, "R7");
        step(1'b1, 1'b1, 1'b0, 1'b0, 7, "R7");
        run(12, 1'b1, "R7");

        // R8: scale change mid-interval applies at next reload only
        step(1'b1, 1'b0, 1'b0, 1'b1, 5, "R8");
        run(8, 1'b1, "R8");
        step(1'b1, 1'b0, 1'b0, 1'b1, 1, "R8");
        run(20, 1'b1, "R8");

        // R9: period change mid-count does not touch the counter
        step(1'b1, 1'b1, 1'b0, 1'b0, 6, "R9");
        run(3, 1'b1, "R9");
        step(1'b1, 1'b0, 1'b1, 1'b0, 2, "R9");
        run(30, 1'b1, "R9");

        // R2: large count value decrements with scale 0
        step(1'b1, 1'b0, 1'b0, 1'b1, 0, "R2");
        step(1'b1, 1'b1, 1'b0, 1'b0, 16'hFFFF, "R2");
        run(10, 1'b1, "R2");
        run(2, 1'b0, "R6");

        @(negedge clk);
        @(negedge clk);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule